// File: doc/BRIEF.md
# Coincident-edge sync pulse generator

This block runs on one fast clock and rebuilds two divided clocks from it, each with its own divide ratio. The two rates may be unrelated, including ratios that are not whole multiples of each other. From the divider phases it predicts the next fast-clock cycle in which both divided clocks rise together. It drives an active-low flag that warns of that cycle, so that downstream logic can align transfers between the two clock domains.

The flag is high during the cycle of a shared rising edge. When the ratios differ, it goes low exactly one period of the faster divided clock before the next shared edge. When the ratios are equal, every edge is shared, so the flag is low for every cycle except the edge cycle.

Synchronous reset starts both dividers together and captures the divide ratios. The divided clocks come out as registered reference copies, which makes their phase visible to the user.

Top module: `coin_sync_gen`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the block sets `clk_a` and `clk_c` to 0 and `sync_n` to 1, and it captures `ratio_a` and `ratio_c`.
- R2: Count the `clk` edges after reset release as k = 1, 2, and so on, with d the captured ratio. After edge k, each divided clock is 1 exactly when ((k-1) mod d) < ceil(d/2). Its first rising edge is therefore at k = 1.
- R3: A captured ratio of 0 or 1 behaves exactly as a ratio of 2.
- R4: Changes on `ratio_a` or `ratio_c` while `rst` is low have no effect on any output until the next reset.
- R5: Let L be the least common multiple of the two effective ratios. After edge k, `sync_n` is 1 whenever ((k-1) mod L) = 0, which is the cycle where both divided clocks rise. `sync_n` goes from 0 to 1 only on such an edge.
- R6: With unequal ratios and m the smaller ratio, `sync_n` is 0 after edge k exactly when ((k-1) mod L) >= L-m. This holds for non-integer rate relations too.
- R7: With unequal ratios, `sync_n` stays 1 for the phases 0 to L-m-1 of every period of L cycles.
- R8: With equal ratios d, `sync_n` is 1 at phase 0 and 0 at phases 1 to d-1 of each divided period.
- R9: `sync_n` changes only at a rising edge of `clk`, as the output of a register.

Ports are listed in the order of the module's port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset; restarts both dividers and captures ratios |
| ratio_a | input | DIV_W | Divide ratio of the first monitored clock |
| ratio_c | input | DIV_W | Divide ratio of the second monitored clock |
| clk_a | output | 1 | Registered copy of the first divided clock |
| clk_c | output | 1 | Registered copy of the second divided clock |
| sync_n | output | 1 | Active-low warning of the next shared rising edge |

## Verification
The assertions assume two things: `rst` is high at the first clock edge, and the ratios are sampled only while reset is held. As a result, the captured ratios and phase counters are valid whenever reset is low. The stimulus holds reset for at least two edges with the ratio inputs already settled. It changes inputs only at falling edges of `clk`, or shortly after a rising edge. All ratio pairs from 2 to 8 are swept, together with out-of-range ratios and ratio changes during operation, and each pair runs for more than two full coincidence periods.

// File: rtl/coin_sync_pkg.sv
package coin_sync_pkg;

    localparam int unsigned MIN_RATIO = 2;

    typedef enum logic [1:0] {
        EV_HOLD     = 2'd0,
        EV_COINCIDE = 2'd1,
        EV_WARN     = 2'd2
    } sync_ev_e;

    function automatic int unsigned clamp_ratio(int unsigned r);
        return (r < MIN_RATIO) ? MIN_RATIO : r;
    endfunction

    function automatic int unsigned lead_target(int unsigned r, int unsigned f);
        return (r == f) ? 0 : r - f;
    endfunction

endpackage

// File: rtl/phase_divider.sv
module phase_divider
    import coin_sync_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] ratio_in,
    output logic [DIV_W-1:0] ratio_q,
    output logic [DIV_W-1:0] phase_nxt,
    output logic             div_clk
);

    logic [DIV_W-1:0] ratio_clamped;
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] half;

    assign ratio_clamped = DIV_W'(clamp_ratio(32'(ratio_in)));
    assign half          = DIV_W'(({1'b0, ratio_q} + (DIV_W+1)'(1)) >> 1);
    assign phase_nxt     = (phase_q == ratio_q - 1'b1) ? '0 : phase_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= ratio_clamped;
            phase_q <= ratio_clamped - 1'b1;
            div_clk <= 1'b0;
        end else begin
            phase_q <= phase_nxt;
            div_clk <= (phase_nxt < half);
        end
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst) phase_q < ratio_q);  // R2
    AST_RISE_ON_PHASE0: assert property (@(posedge clk) disable iff (rst) $rose(div_clk) |-> (phase_q == '0));  // R2
    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (rst) ratio_q >= DIV_W'(MIN_RATIO));  // R3
    AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> $stable(ratio_q));  // R4

endmodule

// File: rtl/sync_predictor.sv
module sync_predictor
    import coin_sync_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] ratio_a,
    input  logic [DIV_W-1:0] ratio_c,
    input  logic [DIV_W-1:0] phase_a_nxt,
    input  logic [DIV_W-1:0] phase_c_nxt,
    output logic             sync_n
);

    logic [DIV_W-1:0] fast;
    logic [DIV_W-1:0] tgt_a;
    logic [DIV_W-1:0] tgt_c;
    logic             same_rate;
    logic             warn_hit;
    sync_ev_e         ev;

    assign fast      = (ratio_a < ratio_c) ? ratio_a : ratio_c;
    assign tgt_a     = DIV_W'(lead_target(32'(ratio_a), 32'(fast)));
    assign tgt_c     = DIV_W'(lead_target(32'(ratio_c), 32'(fast)));
    assign same_rate = (ratio_a == ratio_c);
    assign warn_hit  = same_rate ? (phase_a_nxt == DIV_W'(1))
                                 : ((phase_a_nxt == tgt_a) && (phase_c_nxt == tgt_c));

    always_comb begin
        if ((phase_a_nxt == '0) && (phase_c_nxt == '0)) begin
            ev = EV_COINCIDE;
        end else if (warn_hit) begin
            ev = EV_WARN;
        end else begin
            ev = EV_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_n <= 1'b1;
        end else begin
            case (ev)
                EV_COINCIDE: sync_n <= 1'b1;
                EV_WARN:     sync_n <= 1'b0;
                default:     sync_n <= sync_n;
            endcase
        end
    end

    AST_WARN_NOT_ON_HIT: assert property (@(posedge clk) disable iff (rst) $fell(sync_n) |-> ($past(ev) == EV_WARN));  // R9

endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen
    import coin_sync_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] ratio_a,
    input  logic [DIV_W-1:0] ratio_c,
    output logic             clk_a,
    output logic             clk_c,
    output logic             sync_n
);

    logic [DIV_W-1:0] ratio_a_q;
    logic [DIV_W-1:0] ratio_c_q;
    logic [DIV_W-1:0] phase_a_nxt;
    logic [DIV_W-1:0] phase_c_nxt;

    phase_divider #(.DIV_W(DIV_W)) u_div_a (
        .clk       (clk),
        .rst       (rst),
        .ratio_in  (ratio_a),
        .ratio_q   (ratio_a_q),
        .phase_nxt (phase_a_nxt),
        .div_clk   (clk_a)
    );

    phase_divider #(.DIV_W(DIV_W)) u_div_c (
        .clk       (clk),
        .rst       (rst),
        .ratio_in  (ratio_c),
        .ratio_q   (ratio_c_q),
        .phase_nxt (phase_c_nxt),
        .div_clk   (clk_c)
    );

    sync_predictor #(.DIV_W(DIV_W)) u_pred (
        .clk         (clk),
        .rst         (rst),
        .ratio_a     (ratio_a_q),
        .ratio_c     (ratio_c_q),
        .phase_a_nxt (phase_a_nxt),
        .phase_c_nxt (phase_c_nxt),
        .sync_n      (sync_n)
    );

    // Low-run length monitor for the warning window
    logic [DIV_W-1:0] low_run;
    logic [DIV_W-1:0] ratio_min;

    assign ratio_min = (ratio_a_q < ratio_c_q) ? ratio_a_q : ratio_c_q;

    always_ff @(posedge clk) begin
        if (rst || sync_n) begin
            low_run <= '0;
        end else if (low_run != '1) begin
            low_run <= low_run + 1'b1;
        end
    end

    AST_HIGH_ON_COINCIDE: assert property (@(posedge clk) disable iff (rst) ($rose(clk_a) && $rose(clk_c)) |-> sync_n);  // R5
    AST_RISE_ONLY_ON_COINCIDE: assert property (@(posedge clk) disable iff (rst) $rose(sync_n) |-> ($rose(clk_a) && $rose(clk_c)));  // R5
    AST_FALL_OFF_COINCIDE: assert property (@(posedge clk) disable iff (rst) $fell(sync_n) |-> !($rose(clk_a) && $rose(clk_c)));  // R6
    AST_LOW_WITHIN_FAST_PERIOD: assert property (@(posedge clk) disable iff (rst) !sync_n |-> (low_run < ratio_min));  // R6

endmodule

// File: tb/sim_coin_sync_gen.sv
`timescale 1ns/1ps
module sim_coin_sync_gen;

    localparam int DIV_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] ratio_a = 5'd2;
    logic [DIV_W-1:0] ratio_c = 5'd2;
    logic             clk_a;
    logic             clk_c;
    logic             sync_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    coin_sync_gen #(.DIV_W(DIV_W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .ratio_a (ratio_a),
        .ratio_c (ratio_c),
        .clk_a   (clk_a),
        .clk_c   (clk_c),
        .sync_n  (sync_n)
    );

    function automatic int gcd(int x, int y);
        int p = x;
        int q = y;
        while (q != 0) begin
            int t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic check1(logic act, logic exp, string tag, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // ia/ic: raw ratios; chg: drive different ratios after release (R4)
    task automatic run(int ia, int ic, bit chg, string pre);
        int ea = (ia < 2) ? 2 : ia;
        int ec = (ic < 2) ? 2 : ic;
        int lcm = (ea * ec) / gcd(ea, ec);
        int m = (ea < ec) ? ea : ec;
        int ncyc = 2 * lcm + 3;
        @(negedge clk);
        rst = 1'b1;
        ratio_a = DIV_W'(ia);
        ratio_c = DIV_W'(ic);
        @(negedge clk);
        @(negedge clk);
        check1(clk_a, 1'b0, "R1", "reset clk_a");
        check1(clk_c, 1'b0, "R1", "reset clk_c");
        check1(sync_n, 1'b1, "R1", "reset sync_n");
        rst = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            int ph;
            int p;
            logic exp_s;
            string stag;
            @(posedge clk);
            #1;
            ph = k - 1;
            p  = ph % lcm;
            if (p == 0) begin
                exp_s = 1'b1; stag = "R5";
            end else if (ea == ec) begin
                exp_s = 1'b0; stag = "R8";
            end else if (p >= lcm - m) begin
                exp_s = 1'b0; stag = "R6";
            end else begin
                exp_s = 1'b1; stag = "R7";
            end
            if (pre != "") stag = pre;
            check1(clk_a, logic'((ph % ea) < (ea + 1) / 2), (pre != "") ? pre : "R2", "clk_a");
            check1(clk_c, logic'((ph % ec) < (ec + 1) / 2), (pre != "") ? pre : "R2", "clk_c");
            check1(sync_n, exp_s, stag, "sync_n");
            if (chg && k == 2) begin
                ratio_a = DIV_W'(ec + 3);
                ratio_c = DIV_W'(2);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // Exhaustive sweep of ratio pairs, integer and non-integer relations
        for (int a = 2; a <= 8; a++) begin
            for (int c = 2; c <= 8; c++) begin
                run(a, c, 1'b0, "");
            end
        end
        // R3: out-of-range ratios act as 2
        run(0, 5, 1'b0, "R3");
        run(1, 3, 1'b0, "R3");
        run(0, 1, 1'b0, "R3");
        run(7, 1, 1'b0, "R3");
        // R4: ratio changes during operation are ignored
        run(3, 5, 1'b1, "R4");
        run(4, 6, 1'b1, "R4");
        run(5, 5, 1'b1, "R4");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule